// File: doc/BRIEF.md
# Integer ALU with Condition Flag

This unit carries out one 32-bit integer arithmetic or compare operation per clock. A decoder outside the unit supplies the two register operands, called `rn` and `rm`, an 8-bit immediate and a 5-bit operation code. Operations that name the zero register in their immediate form expect the decoder to route that register onto `rn`. The unit returns a result, a write strobe for the destination register and a single condition flag, T. All three outputs are registered, so each appears one clock after its operation is presented.

T is one bit held inside the unit. It has several jobs: it is the carry of add-with-carry, the borrow of subtract- and negate-with-borrow, the signed overflow flag of the checked add and subtract, and the outcome of every compare and test. The carry-chained operations read the T value currently held in the register. A long chain of add-with-carry or subtract-with-borrow operations can therefore be issued on back-to-back cycles. Operations that define no T outcome leave the flag unchanged.

Top module: `tflag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `res_q` = 0, `wr_q` = 0 and `t_q` = 0.
- R2: Each operation presented at a clock edge updates `res_q`, `wr_q` and `t_q` at that same edge, and they hold until the next edge. Codes 0 (no-op) and 23 to 31 (unused) give `wr_q` = 0, `res_q` = 0 and leave T unchanged.
- R3: Code 1 writes `rn + rm`, code 4 writes `rn - rm` and code 7 writes `0 - rm`, all modulo 2^32, with `wr_q` = 1 and T unchanged.
- R4: Code 2 writes `rn + rm + T`, and T becomes the carry out of bit 31. Code 5 writes `rn - rm - T`, and T becomes 1 when the exact unsigned difference is negative. Code 8 writes `0 - rm - T`, with T set to its borrow in the same way.
- R5: Code 3 writes `rn + rm` and code 6 writes `rn - rm`. In both cases T becomes 1 exactly when the two's-complement result does not fit in 32 signed bits.
- R6: The two-operand compares give `wr_q` = 0 and set T to 1 when their condition holds and to 0 otherwise. The codes are: 9 for `rn == rm`, 10 for unsigned `rn >= rm`, 11 for signed `rn >= rm`, 12 for unsigned `rn > rm`, and 13 for signed `rn > rm`.
- R7: Code 14 sets T to signed `rn > 0` and code 15 sets T to signed `rn >= 0`. Neither writes a register.
- R8: Code 16 sets T to 1 when `rn` equals the immediate sign-extended from 8 to 32 bits, and to 0 otherwise. It does not write a register.
- R9: Code 17 sets T to 1 when, for at least one byte lane i (bits 8i+7..8i, i = 0..3), `rn` and `rm` hold equal bytes. It does not write a register.
- R10: Code 18 sets T to 1 when `rn & rm` is zero. Code 19 sets T to 1 when `rn` ANDed with the zero-extended immediate is zero. Otherwise T is set to 0, and neither code writes a register.
- R11: Code 20 writes `rn - 1` with `wr_q` = 1 and sets T to 1 when that new value is zero, else to 0.
- R12: Code 21 sets T to 0 and code 22 sets T to 1. Neither writes a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code (see requirements) |
| rn | input | W (32) | First operand and destination value source |
| rm | input | W (32) | Second operand |
| imm8 | input | 8 | Immediate for codes 16 and 19 |
| res_q | output | W (32) | Registered result, zero when not writing |
| wr_q | output | 1 | Registered destination write strobe |
| t_q | output | 1 | Registered T flag |

## Verification
The sweep crosses every code with operand pairs at the signed and unsigned boundaries (0, 1, the largest positive, the most negative, all ones, and byte patterns that match in some lanes only), with T preloaded to both 0 and 1. A design that ignored incoming T in the chained forms would be off by one on half of those runs. A design that inverted the borrow sense would report a borrow on `0 - 0`, and one that took overflow from the unsigned carry would flag `0x7FFFFFFF + 1` wrongly in the other direction. Zero-extending the compare immediate would miss `0xFFFFFF80` against immediate `0x80`. A compare that left T alone on a false result, or a decrement whose test came from the old value, would show a stale T right after the preloaded flag.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;
  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_ADDC  = 5'd2,
    OP_ADDV  = 5'd3,
    OP_SUB   = 5'd4,
    OP_SUBC  = 5'd5,
    OP_SUBV  = 5'd6,
    OP_NEG   = 5'd7,
    OP_NEGC  = 5'd8,
    OP_EQ    = 5'd9,
    OP_HS    = 5'd10,
    OP_GE    = 5'd11,
    OP_HI    = 5'd12,
    OP_GT    = 5'd13,
    OP_PL    = 5'd14,
    OP_PZ    = 5'd15,
    OP_EQI   = 5'd16,
    OP_BYTE  = 5'd17,
    OP_TST   = 5'd18,
    OP_TSTI  = 5'd19,
    OP_DT    = 5'd20,
    OP_CLRT  = 5'd21,
    OP_SETT  = 5'd22
  } alu_op_e;

  typedef struct packed {
    logic sub;
    logic use_t;
    logic zero_a;
    logic one_b;
  } addsub_ctl_t;
endpackage

// File: rtl/tflag_addsub.sv
module tflag_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cy_bw,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    sum   = full[W-1:0];
    cy_bw = sub ? ~full[W] : full[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/tflag_compare.sv
module tflag_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] rn,
  input  logic [W-1:0] rm,
  input  logic [7:0]   imm8,
  output logic         eq,
  output logic         hs,
  output logic         hi,
  output logic         ge,
  output logic         gt,
  output logic         pl,
  output logic         pz,
  output logic         eq_imm,
  output logic         byte_hit,
  output logic         and_zero,
  output logic         and_imm_zero
);
  localparam int LANES = W / 8;

  logic [LANES-1:0] lane_eq;
  logic [W-1:0]     imm_sx;
  logic [W-1:0]     imm_zx;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_eq[i] = (rn[8*i +: 8] == rm[8*i +: 8]);
  end

  always_comb begin
    imm_sx       = {{(W-8){imm8[7]}}, imm8};
    imm_zx       = {{(W-8){1'b0}}, imm8};
    eq           = (rn == rm);
    hs           = (rn >= rm);
    hi           = (rn > rm);
    ge           = ($signed(rn) >= $signed(rm));
    gt           = ($signed(rn) > $signed(rm));
    pz           = ~rn[W-1];
    pl           = ~rn[W-1] && (rn != '0);
    eq_imm       = (rn == imm_sx);
    byte_hit     = |lane_eq;
    and_zero     = ((rn & rm) == '0);
    and_imm_zero = ((rn & imm_zx) == '0);
  end
endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
  import tflag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   op_sel,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] rm,
  input  logic [7:0]   imm8,
  output logic [W-1:0] res_q,
  output logic         wr_q,
  output logic         t_q
);
  alu_op_e     op;
  addsub_ctl_t ctl;
  logic [W-1:0] as_a, as_b, as_sum;
  logic         as_cy, as_ovf;
  logic         c_eq, c_hs, c_hi, c_ge, c_gt, c_pl, c_pz;
  logic         c_eqi, c_byte, c_andz, c_andiz;
  logic [W-1:0] nxt_res;
  logic         nxt_wr, nxt_t;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    ctl = '0;
    case (op)
      OP_ADDC:                   ctl.use_t = 1'b1;
      OP_SUB, OP_SUBV:           ctl.sub   = 1'b1;
      OP_SUBC: begin             ctl.sub   = 1'b1; ctl.use_t = 1'b1; end
      OP_NEG:  begin             ctl.sub   = 1'b1; ctl.zero_a = 1'b1; end
      OP_NEGC: begin
        ctl.sub = 1'b1; ctl.zero_a = 1'b1; ctl.use_t = 1'b1;
      end
      OP_DT:   begin             ctl.sub   = 1'b1; ctl.one_b = 1'b1; end
      default: ctl = '0;
    endcase
    as_a = ctl.zero_a ? '0 : rn;
    as_b = ctl.one_b ? {{(W-1){1'b0}}, 1'b1} : rm;
  end

  tflag_addsub #(.W(W)) u_addsub (
    .a     (as_a),
    .b     (as_b),
    .sub   (ctl.sub),
    .cin   (ctl.use_t & t_q),
    .sum   (as_sum),
    .cy_bw (as_cy),
    .ovf   (as_ovf)
  );

  tflag_compare #(.W(W)) u_cmp (
    .rn           (rn),
    .rm           (rm),
    .imm8         (imm8),
    .eq           (c_eq),
    .hs           (c_hs),
    .hi           (c_hi),
    .ge           (c_ge),
    .gt           (c_gt),
    .pl           (c_pl),
    .pz           (c_pz),
    .eq_imm       (c_eqi),
    .byte_hit     (c_byte),
    .and_zero     (c_andz),
    .and_imm_zero (c_andiz)
  );

  always_comb begin
    nxt_res = '0;
    nxt_wr  = 1'b0;
    nxt_t   = t_q;
    case (op)
      OP_ADD, OP_SUB, OP_NEG: begin
        nxt_res = as_sum; nxt_wr = 1'b1;
      end
      OP_ADDC, OP_SUBC, OP_NEGC: begin
        nxt_res = as_sum; nxt_wr = 1'b1; nxt_t = as_cy;
      end
      OP_ADDV, OP_SUBV: begin
        nxt_res = as_sum; nxt_wr = 1'b1; nxt_t = as_ovf;
      end
      OP_DT: begin
        nxt_res = as_sum; nxt_wr = 1'b1; nxt_t = (as_sum == '0);
      end
      OP_EQ:   nxt_t = c_eq;
      OP_HS:   nxt_t = c_hs;
      OP_GE:   nxt_t = c_ge;
      OP_HI:   nxt_t = c_hi;
      OP_GT:   nxt_t = c_gt;
      OP_PL:   nxt_t = c_pl;
      OP_PZ:   nxt_t = c_pz;
      OP_EQI:  nxt_t = c_eqi;
      OP_BYTE: nxt_t = c_byte;
      OP_TST:  nxt_t = c_andz;
      OP_TSTI: nxt_t = c_andiz;
      OP_CLRT: nxt_t = 1'b0;
      OP_SETT: nxt_t = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      t_q   <= 1'b0;
    end else begin
      res_q <= nxt_res;
      wr_q  <= nxt_wr;
      t_q   <= nxt_t;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!t_q && !wr_q && res_q == '0)); // R1

  AST_IDLE_HOLDS_T: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd0 || op_sel > 5'd22) |=> (!wr_q && t_q == $past(t_q))); // R2

  AST_PLAIN_KEEPS_T: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd1 || op_sel == 5'd4 || op_sel == 5'd7) |=> (wr_q && t_q == $past(t_q))); // R3

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 5'd9 && op_sel <= 5'd19) |=> (!wr_q && res_q == '0)); // R6

  AST_HI_IMPLIES_HS: assert property (@(posedge clk) disable iff (rst)
    c_hi |-> (c_hs && !c_eq)); // R6

  AST_GT_IMPLIES_GE: assert property (@(posedge clk) disable iff (rst)
    c_gt |-> c_ge); // R6

  AST_PL_IMPLIES_PZ: assert property (@(posedge clk) disable iff (rst)
    c_pl |-> c_pz); // R7

  AST_DT_HITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd20 && rn == {{(W-1){1'b0}}, 1'b1}) |=> (t_q && wr_q && res_q == '0)); // R11

  AST_SETT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd22) |=> (t_q && !wr_q)); // R12

  AST_CLRT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd21) |=> (!t_q && !wr_q)); // R12
endmodule

// File: tb/tb_tflag_alu.sv
`timescale 1ns/1ps
module tb_tflag_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_sel;
  logic [31:0] rn, rm;
  logic [7:0]  imm8;
  logic [31:0] res_q;
  logic        wr_q, t_q;

  int checks = 0;
  int failures = 0;
  logic mt;

  always #5 clk = ~clk;

  tflag_alu #(.W(32)) dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .rn(rn), .rm(rm),
    .imm8(imm8), .res_q(res_q), .wr_q(wr_q), .t_q(t_q)
  );

  function automatic string req_of(input int op);
    case (op)
      1, 4, 7:           return "R3";
      2, 5, 8:           return "R4";
      3, 6:              return "R5";
      9, 10, 11, 12, 13: return "R6";
      14, 15:            return "R7";
      16:                return "R8";
      17:                return "R9";
      18, 19:            return "R10";
      20:                return "R11";
      21, 22:            return "R12";
      default:           return "R2";
    endcase
  endfunction

  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] im, input logic t,
                       output logic [31:0] r, output logic w, output logic tn);
    logic [32:0] wide;
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = 32'd0; w = 1'b0; tn = t;
    case (op)
      1: begin r = a + b; w = 1'b1; end
      4: begin r = a - b; w = 1'b1; end
      7: begin r = 32'd0 - b; w = 1'b1; end
      2: begin wide = {1'b0, a} + {1'b0, b} + {32'd0, t}; r = wide[31:0]; w = 1'b1; tn = wide[32]; end
      5: begin wide = {1'b0, a} - {1'b0, b} - {32'd0, t}; r = wide[31:0]; w = 1'b1; tn = wide[32]; end
      8: begin wide = 33'd0 - {1'b0, b} - {32'd0, t}; r = wide[31:0]; w = 1'b1; tn = wide[32]; end
      3: begin s = sa + sb; r = a + b; w = 1'b1; tn = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      6: begin s = sa - sb; r = a - b; w = 1'b1; tn = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      9:  tn = (a == b);
      10: tn = (a >= b);
      11: tn = (sa >= sb);
      12: tn = (a > b);
      13: tn = (sa > sb);
      14: tn = (sa > 0);
      15: tn = (sa >= 0);
      16: tn = (sa == longint'($signed(im)));
      17: tn = (a[7:0] == b[7:0]) || (a[15:8] == b[15:8]) ||
               (a[23:16] == b[23:16]) || (a[31:24] == b[31:24]);
      18: tn = ((a & b) == 32'd0);
      19: tn = ((a & {24'd0, im}) == 32'd0);
      20: begin r = a - 32'd1; w = 1'b1; tn = (r == 32'd0); end
      21: tn = 1'b0;
      22: tn = 1'b1;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input int op, input logic [31:0] a, input logic [31:0] b,
                     input logic [7:0] im);
    logic [31:0] er; logic ew, et;
    @(negedge clk);
    op_sel = op[4:0]; rn = a; rm = b; imm8 = im;
    model(op, a, b, im, mt, er, ew, et);
    @(negedge clk);
    check(req_of(op), "res", res_q, er);
    check(req_of(op), "wr", {31'd0, wr_q}, {31'd0, ew});
    check(req_of(op), "t", {31'd0, t_q}, {31'd0, et});
    mt = et;
  endtask

  logic [31:0] vals [12];

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vals = '{32'h0, 32'h1, 32'h2, 32'h7F, 32'h80, 32'hFFFFFF80, 32'h7FFFFFFF,
             32'h80000000, 32'hFFFFFFFF, 32'h12345678, 32'h12AB56CD, 32'hFF00FF00};
    rst = 1'b1; op_sel = 5'd22; rn = '0; rm = '0; imm8 = '0;
    repeat (2) @(negedge clk);
    // R1: reset state, even with a set-flag code on the inputs
    check("R1", "res", res_q, 32'd0);
    check("R1", "wr", {31'd0, wr_q}, 32'd0);
    check("R1", "t", {31'd0, t_q}, 32'd0);
    rst = 1'b0; op_sel = 5'd0;
    mt = 1'b0;

    // R2: outputs hold over idle cycles, unused codes do nothing
    run(22, 32'h0, 32'h0, 8'h0);
    run(0, 32'hFFFFFFFF, 32'h1, 8'hFF);
    run(23, 32'h1, 32'h1, 8'h1);
    run(31, 32'h0, 32'h0, 8'h0);

    // Main sweep over every code, operand pairs and both incoming T values
    for (int op = 0; op < 25; op++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          for (int tv = 0; tv < 2; tv++) begin
            run(tv == 0 ? 21 : 22, 32'h0, 32'h0, 8'h0);
            run(op == 24 ? 31 : op, vals[i], vals[j], vals[j][7:0]);
          end
        end
      end
    end

    // R8: sign extension of the immediate at the boundary
    run(16, 32'hFFFFFF80, 32'h0, 8'h80);
    run(16, 32'h00000080, 32'h0, 8'h80);
    // R11: decrement wrapping from zero
    run(20, 32'h0, 32'h0, 8'h0);
    // R1: reset in mid-run clears a set flag
    run(22, 32'h0, 32'h0, 8'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "t", {31'd0, t_q}, 32'd0);
    rst = 1'b0; mt = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule